// File: doc/BRIEF.md
# EDID Store with Display Data Channel Slave

This block keeps a sink's display identification data in a 512-byte on-chip RAM and hands it to a video source over the display data channel, a two-wire I2C-style bus. The RAM has no initial content: after power-up a local host fills it through a simple synchronous write port, then raises a ready level. Until then the bus side stays silent.

The storage is split in one of two ways. In single mode it is one 512-byte image, and the source reaches the upper half through a segment pointer at a second bus address. In dual mode it is two independent 256-byte images, and a select input decides which one the bus serves. Sink-side reads use an auto-incrementing word offset that wraps inside the selected 256-byte window.

SCL and SDA are oversampled by the block clock. SDA is driven open-drain: the block only ever asks for the line to be pulled low.

Top module: `edid_ddc_top`

## Requirements
- R1: While reset is asserted and right after it, sda_oe_o is 0. The word offset and segment pointer start at 0, so a read right after reset returns RAM byte 0 and then byte 1.
- R2: A host write (host_we_i high at a clock edge) stores host_wdata_i at host_addr_i (0 to 511). A later bus read of that location returns the new value, in both 256-byte halves.
- R3: While edid_ready_i is 0, no address is acknowledged (the ninth bit reads 1), and sda_oe_o is 0 one cycle after edid_ready_i is 0.
- R4: The address byte 0xA0 (device 0x50, write) is acknowledged. The first data byte after it sets the word offset. A following read (address byte 0xA1) returns bytes MSB first, starting at that offset.
- R5: Each byte sent advances the word offset by one. The offset wraps from 0xFF to 0x00 inside the same 256-byte window.
- R6: In single mode, a data byte written to address byte 0x60 (device 0x30, write) sets the segment pointer. Reads then come from RAM address {segment bit 0, offset}, so segment 1 reaches bytes 256 to 511.
- R7: A STOP clears the segment pointer to 0. A repeated START does not clear it.
- R8: In dual mode (dual_mode_i = 1), reads come from RAM address {image_sel_i, offset}, and the segment pointer has no effect.
- R9: The block does not acknowledge any other device address, or a read at device 0x30 (address byte 0x61). It does not drive SDA for such a transfer.
- R10: After the master answers a read byte with NACK (SDA high on the ninth clock), the block releases SDA until the next START. Further clocks read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 9 | Host write byte address |
| host_wdata_i | input | 8 | Host write data |
| edid_ready_i | input | 1 | Contents valid, enables bus answers |
| dual_mode_i | input | 1 | 1 selects two 256-byte images |
| image_sel_i | input | 1 | Image served in dual mode |

## Verification
The bench goes after offset wrap at 0xFF in both halves. A design that carried into the bank bit would read byte 0x100 instead of byte 0x000, or byte 0x200 past the end. It checks that the segment pointer survives repeated STARTs but dies at STOP; a design that got either wrong would return the wrong half on the following read. It checks that dual mode ignores a written segment and follows image_sel_i, and that unready, foreign-address and 0x30-read transfers are left unacknowledged. After a master NACK it clocks a further byte to show that a slave still driving would corrupt it away from 0xFF.

// File: rtl/edid_ddc_pkg.sv
package edid_ddc_pkg;
  localparam logic [6:0] DATA_DEV = 7'h50;
  localparam logic [6:0] SEG_DEV  = 7'h30;
  localparam int         WIN_W    = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } ddc_state_e;
endpackage

// File: rtl/edid_ddc_sync.sv
module edid_ddc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // data edges only count while clock is high on both samples
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/edid_ddc_ram.sv
module edid_ddc_ram #(
  parameter int DEPTH = 512,
  parameter int DW    = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [DW-1:0]            rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/edid_ddc_slave.sv
module edid_ddc_slave
  import edid_ddc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ready_i,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] mem_q_i,
  output logic [7:0] offset_o,
  output logic [7:0] seg_o,
  output logic       sda_low_o,
  output logic       byte_load_o
);
  ddc_state_e state_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shreg_q, tx_q;
  logic       is_read_q, to_seg_q, first_wr_q, ack_seen_q;
  logic       byte_in_done, addr_hit;

  assign byte_in_done = scl_fall_i && (bit_cnt_q == 4'd8);
  assign addr_hit     = (shreg_q[7:1] == DATA_DEV) ||
                        ((shreg_q[7:1] == SEG_DEV) && !shreg_q[0]);

  always_comb begin
    byte_load_o = 1'b0;
    if (ready_i && !start_i && !stop_i && scl_fall_i) begin
      if (state_q == ST_ADDR_ACK && is_read_q) byte_load_o = 1'b1;
      if (state_q == ST_RD_ACK && ack_seen_q)  byte_load_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      tx_q       <= '0;
      sda_low_o  <= 1'b0;
      offset_o   <= '0;
      seg_o      <= '0;
      is_read_q  <= 1'b0;
      to_seg_q   <= 1'b0;
      first_wr_q <= 1'b0;
      ack_seen_q <= 1'b0;
    end else begin
      if (stop_i) seg_o <= '0;
      if (byte_load_o) begin
        tx_q      <= mem_q_i;
        sda_low_o <= ~mem_q_i[7];
        offset_o  <= offset_o + 8'd1;
        bit_cnt_q <= '0;
        state_q   <= ST_RD;
      end else if (!ready_i) begin
        state_q   <= ST_IDLE;
        sda_low_o <= 1'b0;
      end else if (start_i) begin
        state_q    <= ST_ADDR;
        bit_cnt_q  <= '0;
        sda_low_o  <= 1'b0;
        first_wr_q <= 1'b1;
      end else if (stop_i) begin
        state_q   <= ST_IDLE;
        sda_low_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              shreg_q   <= {shreg_q[6:0], sda_s_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (byte_in_done) begin
              if (addr_hit) begin
                state_q   <= ST_ADDR_ACK;
                sda_low_o <= 1'b1;
                is_read_q <= shreg_q[0];
                to_seg_q  <= (shreg_q[7:1] == SEG_DEV);
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              sda_low_o <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_WR;
            end
          end
          ST_WR: begin
            if (scl_rise_i) begin
              shreg_q   <= {shreg_q[6:0], sda_s_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (byte_in_done) begin
              sda_low_o <= 1'b1;
              state_q   <= ST_WR_ACK;
              if (to_seg_q) begin
                seg_o <= shreg_q;
              end else if (first_wr_q) begin
                offset_o   <= shreg_q;
                first_wr_q <= 1'b0;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              sda_low_o <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall_i) begin
              if (bit_cnt_q == 4'd7) begin
                sda_low_o <= 1'b0;
                state_q   <= ST_RD_ACK;
              end else begin
                tx_q      <= {tx_q[6:0], 1'b0};
                sda_low_o <= ~tx_q[6];
                bit_cnt_q <= bit_cnt_q + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) ack_seen_q <= ~sda_s_i;
            else if (scl_fall_i) state_q <= ST_IDLE;  // master NACK
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/edid_ddc_top.sv
module edid_ddc_top
  import edid_ddc_pkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe_o,
  input  logic                     host_we_i,
  input  logic [$clog2(DEPTH)-1:0] host_addr_i,
  input  logic [7:0]               host_wdata_i,
  input  logic                     edid_ready_i,
  input  logic                     dual_mode_i,
  input  logic                     image_sel_i
);
  localparam int AW = $clog2(DEPTH);

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]    mem_q, offset_q, seg_q;
  logic          sda_low, byte_load, bank;
  logic [AW-1:0] rd_addr;

  edid_ddc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  edid_ddc_slave u_slave (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ready_i     (edid_ready_i),
    .sda_s_i     (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .mem_q_i     (mem_q),
    .offset_o    (offset_q),
    .seg_o       (seg_q),
    .sda_low_o   (sda_low),
    .byte_load_o (byte_load)
  );

  // dual mode: select input owns the bank bit, segment ignored
  assign bank    = dual_mode_i ? image_sel_i : seg_q[0];
  assign rd_addr = AW'({bank, offset_q});

  edid_ddc_ram #(.DEPTH(DEPTH), .DW(8)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (host_we_i),
    .waddr_i (host_addr_i),
    .wdata_i (host_wdata_i),
    .raddr_i (rd_addr),
    .rdata_o (mem_q)
  );

  assign sda_oe_o = sda_low;
endmodule

module edid_ddc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       edid_ready_i,
  input logic       sda_oe_o,
  input logic       scl_s,
  input logic       stop_det,
  input logic       byte_load,
  input logic [7:0] seg_q,
  input logic [7:0] offset_q
);
  AST_RESET_RELEASED: assert property (@(posedge clk_i) !rst_ni |-> !sda_oe_o); // R1

  AST_UNREADY_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edid_ready_i |=> !sda_oe_o); // R3

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && $past(edid_ready_i)) |-> !$past(scl_s)); // R4

  AST_OFFSET_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_load |=> (offset_q == 8'($past(offset_q) + 8'd1))); // R5

  AST_SEG_CLEARED_BY_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (seg_q == 8'd0)); // R7
endmodule

bind edid_ddc_top edid_ddc_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .edid_ready_i (edid_ready_i),
  .sda_oe_o     (sda_oe_o),
  .scl_s        (scl_s),
  .stop_det     (stop_det),
  .byte_load    (byte_load),
  .seg_q        (seg_q),
  .offset_q     (offset_q)
);

// File: tb/edid_ddc_top_bench.sv
module edid_ddc_top_bench;
  localparam int H = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic       host_we = 1'b0, ready = 1'b0, dual = 1'b0, sel = 1'b0;
  logic [8:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       sda_oe, sda_line;

  assign sda_line = sda_m & ~sda_oe;

  edid_ddc_top u_edid_ddc_top (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .sda_oe_o     (sda_oe),
    .host_we_i    (host_we),
    .host_addr_i  (host_addr),
    .host_wdata_i (host_wdata),
    .edid_ready_i (ready),
    .dual_mode_i  (dual),
    .image_sel_i  (sel)
  );

  int checks = 0, errors = 0;
  logic [7:0] model [512];
  logic [7:0] exp_q [$];
  logic [7:0] obs_q [$];
  string      tag_q [$];
  event       obs_ev;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    logic [7:0] v;
    v = 8'(a * 37 + 11);
    if (a >= 256) v = v ^ 8'h5A;
    return v;
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic clock_bit(input logic b, output logic r);
    sda_m = b;    tick(H);
    scl_m = 1'b1; tick(H / 2);
    r = sda_line; tick(H / 2);
    scl_m = 1'b0; tick(5);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] v);
    logic r;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, r);
      v = {v[6:0], r};
    end
    clock_bit(~mack, r);
  endtask

  task automatic expect_ack(input logic [7:0] b, input logic want, input string req);
    logic a;
    send_byte(b, a);
    check(a == want, req, 32'(a), 32'(want));
  endtask

  task automatic host_write(input int a, input logic [7:0] d);
    host_we = 1'b1; host_addr = 9'(a); host_wdata = d;
    tick(1);
    host_we = 1'b0;
    model[a] = d;
  endtask

  task automatic point(input logic [7:0] off, input string req);
    bus_start();
    expect_ack(8'hA0, 1'b1, req);
    expect_ack(off, 1'b1, req);
    bus_start();
    expect_ack(8'hA1, 1'b1, req);
  endtask

  task automatic set_seg(input logic [7:0] s, input string req);
    bus_start();
    expect_ack(8'h60, 1'b1, req);
    expect_ack(s, 1'b1, req);
  endtask

  // driver side: expected bytes into the scoreboard, observed bytes to monitor
  task automatic read_run(input int base, input int off, input int n, input string req, input logic fin_stop);
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      exp_q.push_back(model[base + ((off + k) % 256)]);
      tag_q.push_back(req);
      read_byte(k != n - 1, v);
      obs_q.push_back(v);
      -> obs_ev;
    end
    if (fin_stop) bus_stop();
  endtask

  initial begin
    forever begin
      @(obs_ev);
      while (obs_q.size() > 0) begin
        logic [7:0] o, e;
        string t;
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(o === e, t, 32'(o), 32'(e));
      end
    end
  end

  initial begin
    tick(150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    tick(3);
    check(sda_oe == 1'b0, "R1 sda released in reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    tick(3);
    check(sda_oe == 1'b0, "R1 sda released after reset", 32'(sda_oe), 0);

    for (int a = 0; a < 512; a++) host_write(a, pat(a));

    // R3: not ready yet
    bus_start();
    expect_ack(8'hA0, 1'b0, "R3 address ignored while unready");
    bus_stop();
    check(sda_oe == 1'b0, "R3 sda idle while unready", 32'(sda_oe), 0);

    ready = 1'b1;
    tick(4);

    // R1: offset and segment from reset
    bus_start();
    expect_ack(8'hA1, 1'b1, "R1 read address ack");
    read_run(0, 0, 2, "R1 offset starts at 0", 1'b1);

    // R4 and R5: offset write, sequential read
    point(8'h10, "R4 set offset");
    read_run(0, 8'h10, 3, "R4 R5 sequential read", 1'b1);

    // R5: wrap in lower window
    point(8'hFE, "R5 set offset near end");
    read_run(0, 8'hFE, 3, "R5 wrap lower window", 1'b1);

    // R6: segment 1 reaches upper half
    set_seg(8'h01, "R6 segment write");
    point(8'h05, "R6 offset in upper");
    read_run(256, 8'h05, 2, "R6 upper half read", 1'b1);

    // R6 and R5: wrap inside the upper window, R7: kept over repeated starts
    set_seg(8'h01, "R6 segment write");
    point(8'hFF, "R6 offset at end");
    read_run(256, 8'hFF, 2, "R5 R6 wrap upper window", 1'b0);
    point(8'h41, "R7 repeated start");
    read_run(256, 8'h41, 1, "R7 segment kept over repeated start", 1'b1);

    // R7: stop cleared the segment
    point(8'h05, "R7 offset after stop");
    read_run(0, 8'h05, 1, "R7 segment cleared by stop", 1'b1);

    // R8: dual mode
    dual = 1'b1;
    sel  = 1'b1;
    point(8'h20, "R8 offset");
    read_run(256, 8'h20, 1, "R8 image 1 served", 1'b1);
    sel = 1'b0;
    set_seg(8'h01, "R8 segment write");
    point(8'h20, "R8 offset");
    read_run(0, 8'h20, 2, "R8 segment ignored in dual mode", 1'b1);
    dual = 1'b0;

    // R9: foreign address and segment read
    bus_start();
    expect_ack(8'hA4, 1'b0, "R9 foreign address nack");
    bus_stop();
    check(sda_oe == 1'b0, "R9 sda idle after foreign address", 32'(sda_oe), 0);
    bus_start();
    expect_ack(8'h61, 1'b0, "R9 segment read nack");
    bus_stop();

    // R10: master nack releases the bus
    point(8'h30, "R10 offset");
    read_run(0, 8'h30, 1, "R10 last byte", 1'b0);
    read_byte(1'b0, v);
    check(v == 8'hFF, "R10 bus released after nack", 32'(v), 32'hFF);
    bus_stop();

    // R2: host rewrite visible in both halves
    host_write(9'h033, 8'hC3);
    host_write(9'h1C4, 8'h3C);
    point(8'h33, "R2 offset");
    read_run(0, 8'h33, 1, "R2 rewritten lower byte", 1'b1);
    set_seg(8'h01, "R2 segment write");
    point(8'hC4, "R2 offset");
    read_run(256, 8'hC4, 1, "R2 rewritten upper byte", 1'b1);

    tick(10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule